// File: doc/BRIEF.md
# Network wake-up event controller

This block holds the wake-up and power-management state of a network controller. It takes the per-frame results that other logic has already worked out: whether the frame passed the normal address filter, whether it matched the magic-packet pattern, and which wake filters matched it. It also watches the link-up signal. From these inputs it sets sticky status bits, raises the PME_Status flag, and drives a power-management event request toward the host. It also records whether the device is in D0 or D3 and uses that state to decide which host transactions it accepts.

Software programs the block through a small register bus. The bus reaches four registers: wake control, filter control, wake status and the power-management control/status word. The magic-packet wake enable is loaded from a non-volatile default at reset, on a reload strobe, and when the PHY loses power. Magic-packet wake and filter-based wake are enabled along separate paths. Once a packet wake has been recorded, further packet wakes are locked out until software clears every packet-received bit. Link-change wakes have a separate lockout, held until software clears the link-change bit.

Top module: `wake_evt_ctrl`

## Requirements
- R1: Reset leaves every status bit, the filter control register, PME_EN and PME_Status at 0 and the device in D0. The APM enable (wake control bit 0) is loaded from `nvm_apm_en` at reset and again on every `nvm_load` pulse.
- R2: Once the APM enable is set, it stays set in both D0 and D3. It is cleared only by an `nvm_load` with `nvm_apm_en`=0 or by a register write of 0 to wake control bit 0.
- R3: A frame with `frame_magic_hit`=1 sets the magic-received bit (wake status bit 0) and PME_Status (PMCSR bit 15), whatever the address-filter result. This happens only while APM is enabled. A magic frame seen while APM is disabled leaves both bits unchanged.
- R4: A frame wakes through the filters only if `frame_addr_pass`=1 and at least one matched filter is enabled in filter control bits [NF-1:0]. Filter i then sets wake status bit i+1 for every matched and enabled filter at the same time, and PME_Status is set.
- R5: While the link-change enable (filter control bit 16) is 1, every transition of `link_up`, rising or falling, sets the link-changed bit (wake status bit 16) and PME_Status in the same clock edge. While the enable is 0, link transitions have no effect.
- R6: While any packet-received bit (wake status bits 0 to NF) is 1, no further frame sets any status bit or PME_Status. The lockout ends only when all of these bits have been cleared.
- R7: While the link-changed bit is 1, link transitions have no effect. This lockout does not block packet wakes.
- R8: The wake status bits and PME_Status are cleared by writing 1 to them. Writing 0 leaves them unchanged. A hardware set in the same cycle as a software clear wins.
- R9: PMCSR holds the device state in bits [1:0], PME_EN in bit 8 and PME_Status in bit 15. Writing 11b to bits [1:0] enters D3 and writing 00b enters D0. Writes of 01b or 10b leave the state unchanged. `dev_in_d3` is 1 in D3.
- R10: `pme_req` is 1 exactly while PME_Status and PME_EN are both 1, aligned with the register state.
- R11: `host_req_grant` is asserted one cycle after a `host_req_valid` request. It is asserted only if the device is in D0 or `host_req_cfg`=1.
- R12: A `phy_pwr_lost` pulse clears filter control, including the link-change enable, and reloads the APM enable from `nvm_apm_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nvm_load | input | 1 | Reload strobe for the non-volatile defaults |
| nvm_apm_en | input | 1 | Non-volatile default of the APM enable |
| phy_pwr_lost | input | 1 | PHY power loss pulse |
| frame_valid | input | 1 | Frame match results are valid this cycle |
| frame_addr_pass | input | 1 | Frame passed the standard address filter |
| frame_magic_hit | input | 1 | Frame matched the magic pattern |
| frame_flt_hit | input | NF | Per-filter wake-filter match vector |
| link_up | input | 1 | Current link state |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 wake control, 1 filter control, 2 wake status, 3 PMCSR |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_re` |
| host_req_valid | input | 1 | Host transaction presented |
| host_req_cfg | input | 1 | Presented transaction is a configuration access |
| host_req_grant | output | 1 | Transaction accepted, one cycle later |
| pme_req | output | 1 | Power-management event request |
| dev_in_d3 | output | 1 | Device is in D3 |

## Verification
Magic frames are sent with the address filter both failing and passing, and with APM both enabled and disabled, including while in D3. This shows that the APM path is independent of the address filter and of the power state. Filter frames are sent with the address filter failing, with only disabled filters matching, and with several enabled filters matching together. These cases separate the address-filter gate, the enable mask and the setting of several bits at once. Partial clears of the received bits, and link toggles made while a link bit is pending, show that the two lockouts are independent. A PME_Status clear that coincides with a link event shows the set-wins priority.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    SEL_WCTL  = 2'd0,
    SEL_FCTL  = 2'd1,
    SEL_WSTAT = 2'd2,
    SEL_PMCSR = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    DST_D0 = 2'b00,
    DST_D3 = 2'b11
  } dstate_e;

  localparam int APM_EN_BIT  = 0;
  localparam int LNK_EN_BIT  = 16;
  localparam int MAG_ST_BIT  = 0;
  localparam int FLT_ST_LSB  = 1;
  localparam int LNK_ST_BIT  = 16;
  localparam int PME_EN_BIT  = 8;
  localparam int PME_ST_BIT  = 15;
endpackage

// File: rtl/wake_cfg.sv
module wake_cfg
  import wake_pkg::*;
#(
  parameter int NF = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nvm_load,
  input  logic          nvm_apm_en,
  input  logic          phy_pwr_lost,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          apm_en,
  output logic [NF-1:0] flt_en,
  output logic          lnk_en
);
  logic wr_wctl, wr_fctl;

  assign wr_wctl = wr_en && (wr_addr == SEL_WCTL);
  assign wr_fctl = wr_en && (wr_addr == SEL_FCTL);

  always_ff @(posedge clk) begin
    if (rst) begin
      apm_en <= nvm_apm_en;
      flt_en <= '0;
      lnk_en <= 1'b0;
    end else if (phy_pwr_lost) begin
      apm_en <= nvm_apm_en;
      flt_en <= '0;
      lnk_en <= 1'b0;
    end else begin
      if (nvm_load)
        apm_en <= nvm_apm_en;
      else if (wr_wctl)
        apm_en <= wr_data[APM_EN_BIT];
      if (wr_fctl) begin
        flt_en <= wr_data[NF-1:0];
        lnk_en <= wr_data[LNK_EN_BIT];
      end
    end
  end

  // R2: the APM enable moves only on a reload, power loss or a control write
  assert_apm_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!nvm_load && !phy_pwr_lost && !wr_wctl) |=> $stable(apm_en));

  // R12: after PHY power loss the filter configuration is empty
  assert_pwr_loss_clear_R12: assert property (@(posedge clk) disable iff (rst)
    phy_pwr_lost |=> (flt_en == '0 && !lnk_en));
endmodule

// File: rtl/wake_status.sv
module wake_status
  import wake_pkg::*;
#(
  parameter int NF = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_valid,
  input  logic          frame_addr_pass,
  input  logic          frame_magic_hit,
  input  logic [NF-1:0] frame_flt_hit,
  input  logic          link_up,
  input  logic          apm_en,
  input  logic [NF-1:0] flt_en,
  input  logic          lnk_en,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          mag_st,
  output logic [NF-1:0] flt_st,
  output logic          lnk_st,
  output logic          wake_set
);
  logic          pkt_lock, frame_ok, mag_set, lnk_set, lnk_evt;
  logic [NF-1:0] flt_set;
  logic          lnk_prev_q, lnk_vld_q;
  logic          wr_stat, clr_mag, clr_lnk;
  logic [NF-1:0] clr_flt;

  assign pkt_lock = mag_st | (|flt_st);
  assign frame_ok = frame_valid & ~pkt_lock;
  assign mag_set  = frame_ok & frame_magic_hit & apm_en;
  assign flt_set  = (frame_ok & frame_addr_pass) ? (frame_flt_hit & flt_en) : '0;

  assign lnk_evt  = lnk_vld_q & (link_up ^ lnk_prev_q);
  assign lnk_set  = lnk_evt & lnk_en & ~lnk_st;

  assign wr_stat  = wr_en && (wr_addr == SEL_WSTAT);
  assign clr_mag  = wr_stat & wr_data[MAG_ST_BIT];
  assign clr_flt  = wr_stat ? wr_data[FLT_ST_LSB +: NF] : '0;
  assign clr_lnk  = wr_stat & wr_data[LNK_ST_BIT];

  assign wake_set = mag_set | (|flt_set) | lnk_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      lnk_prev_q <= 1'b0;
      lnk_vld_q  <= 1'b0;
    end else begin
      lnk_prev_q <= link_up;
      lnk_vld_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_st <= 1'b0;
      lnk_st <= 1'b0;
    end else begin
      mag_st <= mag_set | (mag_st & ~clr_mag);
      lnk_st <= lnk_set | (lnk_st & ~clr_lnk);
    end
  end

  for (genvar i = 0; i < NF; i++) begin : g_flt_st
    always_ff @(posedge clk) begin
      if (rst) flt_st[i] <= 1'b0;
      else     flt_st[i] <= flt_set[i] | (flt_st[i] & ~clr_flt[i]);
    end
  end

  // R3: the magic bit rises only on a magic frame with APM enabled
  assert_magic_needs_apm_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mag_st) |-> $past(apm_en && frame_valid && frame_magic_hit));

  // R6: while a packet bit is pending and no clear is written, no new packet bit appears
  assert_pkt_lockout_R6: assert property (@(posedge clk) disable iff (rst)
    (pkt_lock && !wr_stat) |=> ((flt_st & ~$past(flt_st)) == '0 && mag_st == $past(mag_st)));

  // R7: a pending link bit survives any link activity until written
  assert_lnk_lockout_R7: assert property (@(posedge clk) disable iff (rst)
    (lnk_st && !wr_stat) |=> lnk_st);

  // R4: a filter bit rises only for an address-passing frame with that filter enabled
  for (genvar j = 0; j < NF; j++) begin : g_flt_chk
    assert_flt_gate_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(flt_st[j]) |-> $past(frame_valid && frame_addr_pass && frame_flt_hit[j] && flt_en[j]));
  end
endmodule

// File: rtl/wake_pm.sv
module wake_pm
  import wake_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wake_set,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          host_req_valid,
  input  logic          host_req_cfg,
  output logic [1:0]    dstate,
  output logic          pme_en,
  output logic          pme_st,
  output logic          pme_req,
  output logic          host_req_grant
);
  logic wr_pm, pme_st_d, pme_en_d, legal_ds;

  assign wr_pm    = wr_en && (wr_addr == SEL_PMCSR);
  assign legal_ds = (wr_data[1:0] == DST_D0) || (wr_data[1:0] == DST_D3);
  assign pme_st_d = wake_set | (pme_st & ~(wr_pm & wr_data[PME_ST_BIT]));
  assign pme_en_d = wr_pm ? wr_data[PME_EN_BIT] : pme_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      dstate         <= DST_D0;
      pme_en         <= 1'b0;
      pme_st         <= 1'b0;
      pme_req        <= 1'b0;
      host_req_grant <= 1'b0;
    end else begin
      if (wr_pm && legal_ds) dstate <= wr_data[1:0];
      pme_en         <= pme_en_d;
      pme_st         <= pme_st_d;
      pme_req        <= pme_st_d & pme_en_d;
      host_req_grant <= host_req_valid & (host_req_cfg | (dstate == DST_D0));
    end
  end

  // R9: only D0 and D3 are ever held
  assert_dstate_legal_R9: assert property (@(posedge clk) disable iff (rst)
    (dstate == DST_D0) || (dstate == DST_D3));

  // R10: the request tracks the flag pair
  assert_pme_req_R10: assert property (@(posedge clk) disable iff (rst)
    pme_req == (pme_st && pme_en));

  // R8: a wake event leaves PME_Status set even against a clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    wake_set |=> pme_st);

  // R11: a non-configuration grant requires D0 in the request cycle
  assert_grant_gate_R11: assert property (@(posedge clk) disable iff (rst)
    host_req_grant |-> $past(host_req_valid && (host_req_cfg || dstate == DST_D0)));
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
  import wake_pkg::*;
#(
  parameter int NF = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nvm_load,
  input  logic          nvm_apm_en,
  input  logic          phy_pwr_lost,
  input  logic          frame_valid,
  input  logic          frame_addr_pass,
  input  logic          frame_magic_hit,
  input  logic [NF-1:0] frame_flt_hit,
  input  logic          link_up,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          host_req_valid,
  input  logic          host_req_cfg,
  output logic          host_req_grant,
  output logic          pme_req,
  output logic          dev_in_d3
);
  logic          apm_en, lnk_en, mag_st, lnk_st, wake_set, pme_en, pme_st;
  logic [NF-1:0] flt_en, flt_st;
  logic [1:0]    dstate;
  logic [DW-1:0] rd_mux;

  wake_cfg #(.NF(NF), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .nvm_load(nvm_load), .nvm_apm_en(nvm_apm_en),
    .phy_pwr_lost(phy_pwr_lost), .wr_en(reg_we), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .apm_en(apm_en), .flt_en(flt_en), .lnk_en(lnk_en)
  );

  wake_status #(.NF(NF), .DW(DW)) u_status (
    .clk(clk), .rst(rst), .frame_valid(frame_valid),
    .frame_addr_pass(frame_addr_pass), .frame_magic_hit(frame_magic_hit),
    .frame_flt_hit(frame_flt_hit), .link_up(link_up), .apm_en(apm_en),
    .flt_en(flt_en), .lnk_en(lnk_en), .wr_en(reg_we), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .mag_st(mag_st), .flt_st(flt_st), .lnk_st(lnk_st),
    .wake_set(wake_set)
  );

  wake_pm #(.DW(DW)) u_pm (
    .clk(clk), .rst(rst), .wake_set(wake_set), .wr_en(reg_we),
    .wr_addr(reg_addr), .wr_data(reg_wdata), .host_req_valid(host_req_valid),
    .host_req_cfg(host_req_cfg), .dstate(dstate), .pme_en(pme_en),
    .pme_st(pme_st), .pme_req(pme_req), .host_req_grant(host_req_grant)
  );

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      SEL_WCTL:  rd_mux[APM_EN_BIT] = apm_en;
      SEL_FCTL: begin
        rd_mux[NF-1:0]   = flt_en;
        rd_mux[LNK_EN_BIT] = lnk_en;
      end
      SEL_WSTAT: begin
        rd_mux[MAG_ST_BIT]         = mag_st;
        rd_mux[FLT_ST_LSB +: NF]   = flt_st;
        rd_mux[LNK_ST_BIT]         = lnk_st;
      end
      SEL_PMCSR: begin
        rd_mux[1:0]        = dstate;
        rd_mux[PME_EN_BIT] = pme_en;
        rd_mux[PME_ST_BIT] = pme_st;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      dev_in_d3 <= 1'b0;
    end else begin
      if (reg_re) reg_rdata <= rd_mux;
      dev_in_d3 <= (reg_we && reg_addr == SEL_PMCSR && reg_wdata[1:0] == DST_D3) ? 1'b1 :
                   (reg_we && reg_addr == SEL_PMCSR && reg_wdata[1:0] == DST_D0) ? 1'b0 :
                   (dstate == DST_D3);
    end
  end

  // R9: the state flag agrees with the held state
  assert_d3_flag_R9: assert property (@(posedge clk) disable iff (rst)
    dev_in_d3 == (dstate == DST_D3));
endmodule

// File: tb/test_wake_evt_ctrl.sv
module test_wake_evt_ctrl;
  localparam int NF = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          nvm_load = 1'b0, nvm_apm_en = 1'b1, phy_pwr_lost = 1'b0;
  logic          frame_valid = 1'b0, frame_addr_pass = 1'b0, frame_magic_hit = 1'b0;
  logic [NF-1:0] frame_flt_hit = '0;
  logic          link_up = 1'b0;
  logic          reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          host_req_valid = 1'b0, host_req_cfg = 1'b0;
  logic          host_req_grant, pme_req, dev_in_d3;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wake_evt_ctrl #(.NF(NF), .DW(DW)) i_wake_evt_ctrl (
    .clk(clk), .rst(rst), .nvm_load(nvm_load), .nvm_apm_en(nvm_apm_en),
    .phy_pwr_lost(phy_pwr_lost), .frame_valid(frame_valid),
    .frame_addr_pass(frame_addr_pass), .frame_magic_hit(frame_magic_hit),
    .frame_flt_hit(frame_flt_hit), .link_up(link_up), .reg_we(reg_we),
    .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_req_valid(host_req_valid),
    .host_req_cfg(host_req_cfg), .host_req_grant(host_req_grant),
    .pme_req(pme_req), .dev_in_d3(dev_in_d3)
  );

  localparam logic [1:0] A_WCTL = 2'd0, A_FCTL = 2'd1, A_WSTAT = 2'd2, A_PM = 2'd3;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    chk(req, reg_rdata, exp);
  endtask

  task automatic frame(input logic mag, input logic ap, input logic [NF-1:0] hit);
    @(negedge clk);
    frame_valid = 1'b1; frame_magic_hit = mag; frame_addr_pass = ap; frame_flt_hit = hit;
    @(negedge clk);
    frame_valid = 1'b0; frame_magic_hit = 1'b0; frame_addr_pass = 1'b0; frame_flt_hit = '0;
  endtask

  task automatic set_link(input logic v);
    @(negedge clk);
    link_up = v;
    @(negedge clk);
  endtask

  task automatic pulse_nvm(input logic v);
    @(negedge clk);
    nvm_apm_en = v; nvm_load = 1'b1;
    @(negedge clk);
    nvm_load = 1'b0;
  endtask

  task automatic clear_all();
    wr(A_WSTAT, 32'h0001_001F);
    wr(A_PM, 32'h0000_8000);
  endtask

  task automatic t_reset();
    chk("R1 pme_req after reset", pme_req, 0);
    chk("R1 d3 after reset", dev_in_d3, 0);
    rd_chk("R1 apm loaded from default", A_WCTL, 32'h1);
    rd_chk("R1 filter control zero", A_FCTL, 32'h0);
    rd_chk("R1 status zero", A_WSTAT, 32'h0);
    rd_chk("R1 pmcsr zero", A_PM, 32'h0);
  endtask

  task automatic t_apm();
    frame(1'b1, 1'b0, '0);
    rd_chk("R3 magic bit without address pass", A_WSTAT, 32'h1);
    rd_chk("R3 PME_Status set by magic", A_PM, 32'h8000);
    chk("R10 no request without PME_EN", pme_req, 0);
    wr(A_PM, 32'h0000_0100);
    chk("R10 request with both flags", pme_req, 1);
    wr(A_PM, 32'h0000_8100);
    chk("R10 request drops on status clear", pme_req, 0);
    wr(A_WSTAT, 32'h1);
    rd_chk("R8 magic bit cleared by write 1", A_WSTAT, 32'h0);
    wr(A_WCTL, 32'h0);
    frame(1'b1, 1'b1, '0);
    rd_chk("R3 magic ignored with APM off", A_WSTAT, 32'h0);
    rd_chk("R3 PME_Status untouched with APM off", A_PM, 32'h100);
    wr(A_WCTL, 32'h1);
    wr(A_PM, 32'h0000_0103);
    chk("R9 enter D3", dev_in_d3, 1);
    rd_chk("R2 APM still on in D3", A_WCTL, 32'h1);
    frame(1'b1, 1'b0, '0);
    chk("R2 magic wakes from D3", pme_req, 1);
    rd_chk("R2 magic bit in D3", A_WSTAT, 32'h1);
    wr(A_PM, 32'h0000_8000);
    wr(A_WSTAT, 32'h1);
    chk("R9 back to D0", dev_in_d3, 0);
  endtask

  task automatic t_filter();
    wr(A_FCTL, 32'h5);
    frame(1'b0, 1'b0, 4'hF);
    rd_chk("R4 address fail ignored", A_WSTAT, 32'h0);
    frame(1'b0, 1'b1, 4'h2);
    rd_chk("R4 disabled filter ignored", A_WSTAT, 32'h0);
    rd_chk("R4 no PME_Status from ignored frames", A_PM, 32'h0);
    frame(1'b0, 1'b1, 4'hF);
    rd_chk("R4 two enabled filters set together", A_WSTAT, 32'h0A);
    rd_chk("R4 PME_Status from filter", A_PM, 32'h8000);
    wr(A_PM, 32'h8000);
    wr(A_FCTL, 32'hF);
    frame(1'b1, 1'b1, 4'h2);
    rd_chk("R6 locked frame ignored", A_WSTAT, 32'h0A);
    rd_chk("R6 locked frame sets no PME_Status", A_PM, 32'h0);
    wr(A_WSTAT, 32'h2);
    rd_chk("R8 partial clear", A_WSTAT, 32'h08);
    frame(1'b0, 1'b1, 4'h2);
    rd_chk("R6 still locked after partial clear", A_WSTAT, 32'h08);
    wr(A_WSTAT, 32'h0);
    rd_chk("R8 write 0 keeps bits", A_WSTAT, 32'h08);
    wr(A_WSTAT, 32'h8);
    frame(1'b0, 1'b1, 4'h2);
    rd_chk("R6 unlocked after full clear", A_WSTAT, 32'h04);
    clear_all();
    wr(A_FCTL, 32'h0);
  endtask

  task automatic t_link();
    set_link(1'b1);
    rd_chk("R5 link change ignored when disabled", A_WSTAT, 32'h0);
    wr(A_FCTL, 32'h0001_0001);
    set_link(1'b0);
    rd_chk("R5 falling link sets bit", A_WSTAT, 32'h0001_0000);
    rd_chk("R5 PME_Status from link", A_PM, 32'h8000);
    wr(A_PM, 32'h8000);
    set_link(1'b1);
    rd_chk("R7 link change locked out", A_PM, 32'h0);
    frame(1'b0, 1'b1, 4'h1);
    rd_chk("R7 packet wake not blocked by link bit", A_WSTAT, 32'h0001_0002);
    wr(A_WSTAT, 32'h0001_0000);
    wr(A_PM, 32'h8000);
    set_link(1'b0);
    rd_chk("R5 link wake after clear", A_WSTAT, 32'h0001_0002);
    clear_all();
  endtask

  task automatic t_setwins();
    frame(1'b1, 1'b0, '0);
    wr(A_WSTAT, 32'h1);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = A_PM; reg_wdata = 32'h8000; link_up = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    rd_chk("R8 set wins over clear", A_PM, 32'h8000);
    rd_chk("R8 link bit from same cycle", A_WSTAT, 32'h0001_0000);
    clear_all();
    wr(A_FCTL, 32'h0);
  endtask

  task automatic t_pmcsr();
    wr(A_PM, 32'h2);
    chk("R9 illegal 10b ignored", dev_in_d3, 0);
    rd_chk("R9 state stays D0", A_PM, 32'h0);
    wr(A_PM, 32'h3);
    rd_chk("R9 D3 encoding", A_PM, 32'h3);
    wr(A_PM, 32'h1);
    rd_chk("R9 illegal 01b ignored", A_PM, 32'h3);
    chk("R9 still D3", dev_in_d3, 1);
  endtask

  task automatic req(input string r, input logic cfg, input logic exp);
    @(negedge clk);
    host_req_valid = 1'b1; host_req_cfg = cfg;
    @(negedge clk);
    host_req_valid = 1'b0; host_req_cfg = 1'b0;
    chk(r, host_req_grant, exp);
  endtask

  task automatic t_access();
    req("R11 memory request refused in D3", 1'b0, 1'b0);
    req("R11 config request accepted in D3", 1'b1, 1'b1);
    wr(A_PM, 32'h0);
    req("R11 memory request accepted in D0", 1'b0, 1'b1);
    @(negedge clk);
    chk("R11 no grant without request", host_req_grant, 0);
  endtask

  task automatic t_nvm_phy();
    pulse_nvm(1'b0);
    rd_chk("R1 reload clears APM enable", A_WCTL, 32'h0);
    nvm_apm_en = 1'b1;
    wr(A_PM, 32'h3);
    rd_chk("R2 default change alone has no effect", A_WCTL, 32'h0);
    pulse_nvm(1'b1);
    rd_chk("R1 reload sets APM enable", A_WCTL, 32'h1);
    wr(A_PM, 32'h0);
    wr(A_WCTL, 32'h0);
    wr(A_FCTL, 32'h0001_0005);
    @(negedge clk);
    phy_pwr_lost = 1'b1;
    @(negedge clk);
    phy_pwr_lost = 1'b0;
    rd_chk("R12 filter control cleared", A_FCTL, 32'h0);
    rd_chk("R12 APM reloaded", A_WCTL, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_apm();
    t_filter();
    t_link();
    t_setwins();
    t_pmcsr();
    t_access();
    t_nvm_phy();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule